// File: doc/BRIEF.md
# Async HDLC Transmitter with Clear-to-Send Loss Handling

This block builds asynchronous HDLC frames from a stream of transmit buffers and hands them byte by byte to a serializer. Each buffer is a run of bytes fetched over a valid/pop handshake, with the final byte of a buffer marked. Every frame is a flag, the escaped buffer bytes, a 16-bit CRC and a closing flag. When a frame ends normally, the block reports a good close on a one-cycle status strobe.

The clear-to-send input matters only while a frame is in progress. If it drops mid-frame, the block sends nothing more from that buffer. It closes the buffer with a CTS-lost status, raises a transmit-error event for one cycle and discards the unsent rest of that buffer. It then parks until a restart command arrives. After the restart it moves on to the next buffer. When clear-to-send is low between frames, the next frame simply waits and no error is raised.

Top module: `hdlcCtsTx`

## Requirements
- R1: Out of reset, txValid, bufPop, statValid, txErrEvt and txParked are all 0.
- R2: Each frame starts with the byte 0x7E, then the buffer bytes in order, then the CRC low byte, then the CRC high byte, and ends with 0x7E.
- R3: A data or CRC byte equal to 0x7E or 0x7D is sent as two bytes: 0x7D, then the original value XOR 0x20.
- R4: The CRC is the reflected CCITT CRC-16 (polynomial 0x8408, initial value 0xFFFF) over the unescaped buffer bytes, bit-inverted before it is sent.
- R5: While a frame is in progress, txValid is 0 in every cycle where cts is 0, so no serializer handshake completes.
- R6: A cycle with cts at 0 during a frame closes the buffer. In the next cycle statValid, statCtsLost and txErrEvt are all 1, for exactly one cycle.
- R7: One cycle after the closing flag is accepted, statValid is 1 with statCtsLost 0 and txErrEvt 0.
- R8: After a CTS-lost close, the remaining bytes of the interrupted buffer are popped without being sent. txParked then goes to 1, and no byte is sent or popped while it stays 1.
- R9: A restartCmd pulse while txParked is 1 clears txParked in the next cycle. Transmission then continues with the buffer after the interrupted one.
- R10: A restartCmd pulse while txParked is 0 has no effect on the outputs.
- R11: A cts of 0 while no frame is in progress holds off the next frame and raises neither statValid nor txErrEvt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bufValid | input | 1 | A buffer byte is available |
| bufData | input | 8 | Current buffer byte |
| bufLast | input | 1 | Current byte is the final one of its buffer |
| bufPop | output | 1 | Current buffer byte is consumed this cycle |
| txByte | output | 8 | Byte offered to the serializer |
| txValid | output | 1 | txByte is valid |
| txReady | input | 1 | Serializer accepts txByte this cycle |
| cts | input | 1 | Clear-to-send, active high |
| restartCmd | input | 1 | Restart command pulse |
| statValid | output | 1 | One-cycle buffer-close strobe |
| statCtsLost | output | 1 | Close was caused by clear-to-send loss |
| txErrEvt | output | 1 | One-cycle transmit-error event |
| txParked | output | 1 | Transmitter is halted and waiting for a restart |

## Verification
The bench drops clear-to-send at three points: in the first cycle of a frame, in the middle of the data, and on the closing flag. A design that misplaced the close would either keep sending bytes from the dead buffer or fail to drain it, and would then restart with the tail of the old buffer instead of the next one. The bench also pulses restart while draining, while idle and while sending. A design that honoured those pulses would leave the parked state early or drift away from the model. Frames with literal 0x7E and 0x7D bytes under a randomly stalling serializer would expose an escape sequence that loses its second byte or lets the CRC advance twice.

// File: rtl/hdlcTxPkg.sv
package hdlcTxPkg;
  localparam logic [7:0] FLAG_BYTE = 8'h7E;
  localparam logic [7:0] ESC_BYTE  = 8'h7D;
  localparam logic [7:0] ESC_XOR   = 8'h20;

  typedef enum logic [2:0] {
    PH_OPEN, PH_DATA, PH_CRC_LO, PH_CRC_HI, PH_CLOSE
  } phaseT;

  typedef enum logic [1:0] {
    ST_IDLE, ST_SEND, ST_DRAIN, ST_PARK
  } ctlStateT;

  typedef struct packed {
    logic start;   // load a fresh frame context
    logic run;     // offer bytes to the serializer
    logic drain;   // discard buffer bytes without sending
  } txStrobeT;

  function automatic logic [15:0] crcStep(input logic [15:0] cur,
                                          input logic [7:0]  data,
                                          input logic [15:0] poly);
    logic [15:0] r;
    r = cur ^ {8'h00, data};
    for (int i = 0; i < 8; i++) begin
      r = r[0] ? ((r >> 1) ^ poly) : (r >> 1);
    end
    return r;
  endfunction
endpackage

// File: rtl/hdlcTxDatapath.sv
module hdlcTxDatapath
  import hdlcTxPkg::*;
#(
  parameter logic [15:0] CRC_POLY = 16'h8408,
  parameter logic [15:0] CRC_INIT = 16'hFFFF
) (
  input  logic       clk,
  input  logic       rstN,
  input  txStrobeT   strb,
  input  logic       bufValid,
  input  logic [7:0] bufData,
  input  logic       bufLast,
  input  logic       txReady,
  output logic [7:0] txByte,
  output logic       txValid,
  output logic       bufPop,
  output logic       frameEnd,
  output logic       bufDone
);
  phaseT       phase;
  logic        escPend;
  logic [15:0] crc;
  logic [7:0]  rawByte;
  logic        isFlagPh;
  logic        needEsc;
  logic        fire;
  logic        byteDone;

  always_comb begin
    case (phase)
      PH_DATA:   rawByte = bufData;
      PH_CRC_LO: rawByte = ~crc[7:0];
      PH_CRC_HI: rawByte = ~crc[15:8];
      default:   rawByte = FLAG_BYTE;
    endcase
  end

  assign isFlagPh = (phase == PH_OPEN) || (phase == PH_CLOSE);
  assign needEsc  = !isFlagPh && ((rawByte == FLAG_BYTE) || (rawByte == ESC_BYTE));

  always_comb begin
    if (isFlagPh)     txByte = FLAG_BYTE;
    else if (escPend) txByte = rawByte ^ ESC_XOR;
    else if (needEsc) txByte = ESC_BYTE;
    else              txByte = rawByte;
  end

  assign txValid  = strb.run && ((phase != PH_DATA) || bufValid);
  assign fire     = txValid && txReady;
  assign byteDone = fire && (!needEsc || escPend);
  assign bufPop   = (byteDone && (phase == PH_DATA)) || (strb.drain && bufValid);
  assign frameEnd = byteDone && (phase == PH_CLOSE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase   <= PH_OPEN;
      escPend <= 1'b0;
      crc     <= CRC_INIT;
      bufDone <= 1'b0;
    end else if (strb.start) begin
      phase   <= PH_OPEN;
      escPend <= 1'b0;
      crc     <= CRC_INIT;
      bufDone <= 1'b0;
    end else if (fire) begin
      if (!byteDone) begin
        escPend <= 1'b1;
      end else begin
        escPend <= 1'b0;
        case (phase)
          PH_OPEN:   phase <= PH_DATA;
          PH_DATA: begin
            crc <= crcStep(crc, bufData, CRC_POLY);
            if (bufLast) begin
              phase   <= PH_CRC_LO;
              bufDone <= 1'b1;
            end
          end
          PH_CRC_LO: phase <= PH_CRC_HI;
          PH_CRC_HI: phase <= PH_CLOSE;
          default:   phase <= PH_OPEN;
        endcase
      end
    end
  end

  // R3
  esc_pair_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fire && (txByte == ESC_BYTE)) |=>
      (!txValid || (txByte == (FLAG_BYTE ^ ESC_XOR)) || (txByte == (ESC_BYTE ^ ESC_XOR))));

  // R2
  close_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameEnd |-> (txByte == FLAG_BYTE));
endmodule

// File: rtl/hdlcTxControl.sv
module hdlcTxControl
  import hdlcTxPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     cts,
  input  logic     restartCmd,
  input  logic     bufValid,
  input  logic     bufLast,
  input  logic     frameEnd,
  input  logic     bufDone,
  output txStrobeT strb,
  output logic     statValid,
  output logic     statCtsLost,
  output logic     txErrEvt,
  output logic     txParked
);
  ctlStateT state;
  ctlStateT stateNxt;
  logic     abortNow;

  assign abortNow   = (state == ST_SEND) && !cts;
  assign strb.start = (state == ST_IDLE) && bufValid && cts;
  assign strb.run   = (state == ST_SEND) && cts;
  assign strb.drain = (state == ST_DRAIN);

  always_comb begin
    stateNxt = state;
    case (state)
      ST_IDLE:  if (strb.start) stateNxt = ST_SEND;
      ST_SEND: begin
        if (abortNow)      stateNxt = bufDone ? ST_PARK : ST_DRAIN;
        else if (frameEnd) stateNxt = ST_IDLE;
      end
      ST_DRAIN: if (bufValid && bufLast) stateNxt = ST_PARK;
      default:  if (restartCmd) stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      statValid   <= 1'b0;
      statCtsLost <= 1'b0;
      txErrEvt    <= 1'b0;
      txParked    <= 1'b0;
    end else begin
      state       <= stateNxt;
      statValid   <= abortNow || frameEnd;
      statCtsLost <= abortNow;
      txErrEvt    <= abortNow;
      txParked    <= (stateNxt == ST_PARK);
    end
  end

  // R6
  cts_abort_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_SEND) && !cts) |=> (txErrEvt && (state != ST_SEND)));

  // R9
  restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_PARK) && restartCmd) |=> (state == ST_IDLE));
endmodule

// File: rtl/hdlcCtsTx.sv
module hdlcCtsTx
  import hdlcTxPkg::*;
#(
  parameter logic [15:0] CRC_POLY = 16'h8408,
  parameter logic [15:0] CRC_INIT = 16'hFFFF
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       bufValid,
  input  logic [7:0] bufData,
  input  logic       bufLast,
  output logic       bufPop,
  output logic [7:0] txByte,
  output logic       txValid,
  input  logic       txReady,
  input  logic       cts,
  input  logic       restartCmd,
  output logic       statValid,
  output logic       statCtsLost,
  output logic       txErrEvt,
  output logic       txParked
);
  txStrobeT strb;
  logic     frameEnd;
  logic     bufDone;

  hdlcTxDatapath #(.CRC_POLY(CRC_POLY), .CRC_INIT(CRC_INIT)) i_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .bufValid (bufValid),
    .bufData  (bufData),
    .bufLast  (bufLast),
    .txReady  (txReady),
    .txByte   (txByte),
    .txValid  (txValid),
    .bufPop   (bufPop),
    .frameEnd (frameEnd),
    .bufDone  (bufDone)
  );

  hdlcTxControl i_control (
    .clk         (clk),
    .rstN        (rstN),
    .cts         (cts),
    .restartCmd  (restartCmd),
    .bufValid    (bufValid),
    .bufLast     (bufLast),
    .frameEnd    (frameEnd),
    .bufDone     (bufDone),
    .strb        (strb),
    .statValid   (statValid),
    .statCtsLost (statCtsLost),
    .txErrEvt    (txErrEvt),
    .txParked    (txParked)
  );

  // R5
  cts_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cts |-> !txValid);

  // R8
  park_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    txParked |-> (!txValid && !bufPop));

  // R7
  done_stat_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameEnd |=> (statValid && !statCtsLost && !txErrEvt));
endmodule

// File: tb/test_hdlcCtsTx.sv
`timescale 1ns/1ps
module test_hdlcCtsTx;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       bufValid = 1'b0;
  logic [7:0] bufData = 8'h00;
  logic       bufLast = 1'b0;
  logic       bufPop;
  logic [7:0] txByte;
  logic       txValid;
  logic       txReady = 1'b0;
  logic       cts = 1'b0;
  logic       restartCmd = 1'b0;
  logic       statValid, statCtsLost, txErrEvt, txParked;

  always #2 clk = ~clk;

  hdlcCtsTx i_hdlcCtsTx (
    .clk(clk), .rstN(rstN), .bufValid(bufValid), .bufData(bufData),
    .bufLast(bufLast), .bufPop(bufPop), .txByte(txByte), .txValid(txValid),
    .txReady(txReady), .cts(cts), .restartCmd(restartCmd),
    .statValid(statValid), .statCtsLost(statCtsLost), .txErrEvt(txErrEvt),
    .txParked(txParked)
  );

  int nChecks = 0;
  int nFail = 0;
  int okFrames = 0;

  // buffer source
  logic [7:0] srcByte[$];
  bit         srcLast[$];
  // expected frame entries: byte, kind (0 flag,1 escape,2 crc,3 data), pop flag
  logic [7:0] expByte[$];
  int         expKind[$];
  bit         expPop[$];

  int  mState = 0;     // 0 idle, 1 sending, 2 draining, 3 parked
  int  curRemain = 0;
  int  frameLen = 0;
  bit  eStatV = 0, eStatC = 0, eEvt = 0, eParked = 0;

  bit  ctsBase = 1;
  bit  readyRand = 0;
  bit  restartReq = 0;
  int  dropArm = -1;
  bit  dropStart = 0;
  int  dropLen = 0;
  int  dropCnt = 0;
  logic [15:0] lfsr = 16'hACE1;

  function automatic logic [15:0] nextRnd();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic pushB(input logic [7:0] b, input bit last);
    srcByte.push_back(b);
    srcLast.push_back(last);
  endtask

  task automatic addRandBuf(input int len);
    for (int i = 0; i < len; i++) begin
      logic [15:0] r;
      r = nextRnd();
      pushB((r[3:0] == 4'h0) ? 8'h7E : (r[3:0] == 4'h1) ? 8'h7D : r[15:8], i == len - 1);
    end
  endtask

  // CRC computed bit by bit, LSB first (R4)
  function automatic logic [15:0] benchCrc(input logic [15:0] c, input logic [7:0] d);
    for (int b = 0; b < 8; b++) begin
      bit fb;
      fb = c[0] ^ d[b];
      c = c >> 1;
      if (fb) c = c ^ 16'h8408;
    end
    return c;
  endfunction

  task automatic pushExp(input logic [7:0] v, input int kind, input bit pop);
    if (kind != 0 && (v == 8'h7E || v == 8'h7D)) begin
      expByte.push_back(8'h7D); expKind.push_back(1); expPop.push_back(1'b0);
      expByte.push_back(v ^ 8'h20); expKind.push_back(1); expPop.push_back(pop);
    end else begin
      expByte.push_back(v); expKind.push_back(kind); expPop.push_back(pop);
    end
  endtask

  task automatic buildFrame();
    logic [15:0] c;
    int n;
    c = 16'hFFFF;
    n = 0;
    expByte.delete(); expKind.delete(); expPop.delete();
    pushExp(8'h7E, 0, 1'b0);
    for (int i = 0; i < srcByte.size(); i++) begin
      pushExp(srcByte[i], 3, 1'b1);
      c = benchCrc(c, srcByte[i]);
      n++;
      if (srcLast[i]) break;
    end
    c = ~c;
    pushExp(c[7:0], 2, 1'b0);
    pushExp(c[15:8], 2, 1'b0);
    pushExp(8'h7E, 0, 1'b0);
    curRemain = n;
    frameLen = expByte.size();
  endtask

  function automatic string kindTag(input int k);
    case (k)
      0: return "R2 flag";
      1: return "R3 escape";
      2: return "R4 crc";
      default: return "R2 data";
    endcase
  endfunction

  task automatic step();
    bit expTx, expPopNow;
    @(posedge clk); #1;
    if (mState == 1 && ((dropArm >= 0 && expByte.size() == dropArm) ||
                        (dropStart && expByte.size() == frameLen))) begin
      dropCnt = dropLen; dropArm = -1; dropStart = 0;
    end
    cts = ctsBase && (dropCnt == 0);
    if (dropCnt > 0) dropCnt--;
    if (readyRand) begin
      logic [15:0] r;
      r = nextRnd();
      txReady = r[0] | r[5];
    end else begin
      txReady = 1'b1;
    end
    restartCmd = restartReq; restartReq = 0;
    bufValid = srcByte.size() > 0;
    bufData  = bufValid ? srcByte[0] : 8'h00;
    bufLast  = bufValid ? srcLast[0] : 1'b0;
    #1;
    // compare
    expTx = (mState == 1) && cts;
    chk(txValid == expTx, "R5 R11 txValid", txValid, expTx);
    if (expTx && txValid) chk(txByte == expByte[0], kindTag(expKind[0]), txByte, expByte[0]);
    expPopNow = (expTx && txReady && expPop[0]) || (mState == 2 && srcByte.size() > 0);
    chk(bufPop == expPopNow, "R8 bufPop", bufPop, expPopNow);
    chk(statValid == eStatV, "R7 statValid", statValid, eStatV);
    if (eStatV) chk(statCtsLost == eStatC, "R6 statCtsLost", statCtsLost, eStatC);
    chk(txErrEvt == eEvt, "R6 R11 txErrEvt", txErrEvt, eEvt);
    chk(txParked == eParked, "R9 R10 txParked", txParked, eParked);
    if (statValid && !statCtsLost) okFrames++;
    // advance model to the next edge
    eStatV = 0; eStatC = 0; eEvt = 0;
    case (mState)
      0: if (bufValid && cts) begin buildFrame(); mState = 1; end
      1: begin
        if (!cts) begin
          eStatV = 1; eStatC = 1; eEvt = 1;
          mState = (curRemain == 0) ? 3 : 2;
          expByte.delete(); expKind.delete(); expPop.delete();
        end else if (txReady) begin
          if (expPop[0]) begin
            void'(srcByte.pop_front()); void'(srcLast.pop_front());
            curRemain--;
          end
          void'(expByte.pop_front()); void'(expKind.pop_front()); void'(expPop.pop_front());
          if (expByte.size() == 0) begin eStatV = 1; mState = 0; end
        end
      end
      2: if (srcByte.size() > 0) begin
        bit l;
        l = srcLast.pop_front();
        void'(srcByte.pop_front());
        if (l) mState = 3;
      end
      default: if (restartCmd) mState = 0;
    endcase
    eParked = (mState == 3);
  endtask

  task automatic waitIdle();
    for (int k = 0; k < 4000; k++) begin
      step();
      if (mState == 0 && srcByte.size() == 0) break;
    end
    step(); step();
  endtask

  initial begin
    #800000;
    nFail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    int okBefore;
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1; cts = 1'b1;
    #1;
    // R1 reset state
    chk(txValid == 0, "R1 txValid", txValid, 0);
    chk(bufPop == 0, "R1 bufPop", bufPop, 0);
    chk(statValid == 0, "R1 statValid", statValid, 0);
    chk(txErrEvt == 0, "R1 txErrEvt", txErrEvt, 0);
    chk(txParked == 0, "R1 txParked", txParked, 0);

    // plain frame, serializer always ready (R2, R4, R7)
    for (int i = 0; i < 5; i++) pushB(8'h30 + i, i == 4);
    okBefore = okFrames;
    waitIdle();
    chk(okFrames == okBefore + 1, "R7 good close count", okFrames, okBefore + 1);

    // literal flag and escape bytes under a stalling serializer (R3)
    readyRand = 1;
    pushB(8'h7E, 0); pushB(8'h7D, 0); pushB(8'h01, 0); pushB(8'h7E, 1);
    waitIdle();

    // cts low between frames holds off start, no error (R11)
    ctsBase = 0;
    addRandBuf(3);
    repeat (12) step();
    chk(txValid == 0 && txErrEvt == 0, "R11 held off", txValid, 0);
    ctsBase = 1;
    waitIdle();

    // restart while idle and while sending is ignored (R10)
    restartReq = 1; step();
    chk(txParked == 0, "R10 idle restart", txParked, 0);
    addRandBuf(6);
    repeat (4) step();
    restartReq = 1; step(); step();
    chk(txParked == 0, "R10 send restart", txParked, 0);
    waitIdle();

    // cts lost in the middle of the data (R6, R8, R9)
    readyRand = 0;
    for (int i = 0; i < 8; i++) pushB(8'h10 + i, i == 7);
    for (int i = 0; i < 3; i++) pushB(8'h40 + i, i == 2);
    dropArm = 8; dropLen = 3;
    okBefore = okFrames;
    for (int k = 0; k < 200 && mState != 2; k++) step();
    restartReq = 1; step();            // restart while draining: ignored (R10)
    for (int k = 0; k < 200 && mState != 3; k++) step();
    repeat (5) step();
    chk(txParked == 1, "R8 parked after drain", txParked, 1);
    chk(okFrames == okBefore, "R8 no frame while parked", okFrames, okBefore);
    restartReq = 1;
    waitIdle();
    chk(okFrames == okBefore + 1, "R9 next buffer sent", okFrames, okBefore + 1);

    // cts lost in the first cycle of a frame (R8)
    readyRand = 1;
    addRandBuf(4);
    addRandBuf(2);
    dropStart = 1; dropLen = 2;
    okBefore = okFrames;
    for (int k = 0; k < 200 && mState != 3; k++) step();
    repeat (3) step();
    chk(txParked == 1, "R8 parked after early loss", txParked, 1);
    restartReq = 1;
    waitIdle();
    chk(okFrames == okBefore + 1, "R9 resume after early loss", okFrames, okBefore + 1);

    // cts lost on the closing flag: buffer already consumed (R6, R8)
    readyRand = 0;
    addRandBuf(4);
    addRandBuf(3);
    dropArm = 1; dropLen = 2;
    okBefore = okFrames;
    for (int k = 0; k < 200 && mState != 3; k++) step();
    repeat (3) step();
    chk(txParked == 1, "R8 parked after close loss", txParked, 1);
    restartReq = 1;
    waitIdle();
    chk(okFrames == okBefore + 1, "R9 resume after close loss", okFrames, okBefore + 1);

    // random traffic
    readyRand = 1;
    for (int f = 0; f < 20; f++) begin
      logic [15:0] r;
      r = nextRnd();
      addRandBuf(1 + int'(r[3:0] % 12));
    end
    waitIdle();

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule